// File: doc/BRIEF.md
# Vertical sync mode detector

This block watches a raw vertical sync line and reports the frame period, the sync polarity and whether a usable sync is present. A measuring tick is made by dividing a base-clock enable by a fixed ratio (76 by default). A frame counter counts ticks from the start of one active sync phase to the start of the next. Polarity is decided by sampling the sync level a quarter of the way through the frame.

A new frame result reaches the outputs only after it has repeated on four frames in a row. When that happens, a one-cycle interrupt goes out together with the new values. Presence has hysteresis. It is set only by a frame shorter than the low threshold, and it is cleared when the counter runs up to the high threshold without seeing an edge. That timeout updates the outputs straight away, so a sync line that stops completely is still reported.

Top module: `vsync_mode_det`

## Requirements
- R1: One measuring tick occurs for every DIV base-enable cycles (DIV defaults to 76). The reported period is in ticks, so halving the enable rate halves the reported period.
- R2: The frame period is the exact number of ticks between two consecutive starts of the active phase. The active phase starts on a rising edge when the measured polarity is 0 and on a falling edge when it is 1.
- R3: `present_o` goes from 0 to 1 only for a frame that measures below LO_TH (default 4032, 0xFC0).
- R4: A frame that measures from LO_TH up to HI_TH-1 leaves `present_o` at its previous value.
- R5: If HI_TH ticks pass with no active edge (default 4080, 0xFF0), `period_o` becomes HI_TH and `present_o` becomes 0, while `pol_o` is kept. The interrupt fires at once, with no persistence wait, and the counter restarts. A timeout that changes nothing raises no interrupt. A measured frame never reaches HI_TH, so the counter never wraps.
- R6: The sync level is sampled on the tick where the count reaches one quarter of the previous measured frame (at least 1). A high sample gives `pol_o`=1 (active-low sync), and a low sample gives 0.
- R7: A new {period, polarity, presence} result is applied on the fourth consecutive frame that shows it. A change that lasts only three frames has no effect.
- R8: `irq_o` is one cycle wide. `period_o`, `pol_o` and `present_o` change only in a cycle where `irq_o` is 1.
- R9: Frames that repeat the reported mode raise no interrupt.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Raw vertical sync |
| base_en_i | input | 1 | Base measurement clock enable |
| period_o | output | CNT_W | Frame period in ticks |
| pol_o | output | 1 | 1 = active-low sync |
| present_o | output | 1 | Sync present |
| irq_o | output | 1 | Mode-change pulse |

## Verification
A wrong persistence count shows up as an interrupt on a three-frame glitch, or as a missing interrupt on a real change. Either is visible within one frame of the fourth repeat. A prescaler or edge-selection fault changes `period_o` on the first mode that settles, which takes a handful of frames. A presence fault shows on the first frame that measures between the thresholds, or on the first timeout.

// File: rtl/vmd_pkg.sv
package vmd_pkg;
  localparam int VMD_DIV     = 76;
  localparam int VMD_CNT_W   = 12;
  localparam int VMD_HI_TH   = 4080;
  localparam int VMD_LO_TH   = 4032;
  localparam int VMD_PERSIST = 4;
endpackage

// File: rtl/vmd_prescaler.sv
module vmd_prescaler
  import vmd_pkg::*;
#(
  parameter int DIV = VMD_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = en_i;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] cnt_q;
      assign tick_o = en_i && (cnt_q == PW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (en_i) cnt_q <= tick_o ? '0 : cnt_q + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/vmd_frame_meter.sv
module vmd_frame_meter
  import vmd_pkg::*;
#(
  parameter int CNT_W = VMD_CNT_W,
  parameter int HI_TH = VMD_HI_TH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             tick_i,
  output logic             evt_o,
  output logic             tout_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             pol_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HI_V    = CNT_W'(HI_TH);

  logic             vs_q, vs_qq, pol_q;
  logic [CNT_W-1:0] cnt_q, prev_q, cnt_inc, qtr;
  logic             frm_edge, hit_to, hit_qtr;

  always_comb begin
    // frame boundary = start of the active phase per current polarity
    frm_edge = pol_q ? (vs_qq & ~vs_q) : (vs_q & ~vs_qq);
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
    qtr      = ((prev_q >> 2) == '0) ? CNT_W'(1) : (prev_q >> 2);
    hit_to   = tick_i && !frm_edge && (cnt_inc >= HI_V);
    hit_qtr  = tick_i && (cnt_inc == qtr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= 1'b0;
      vs_qq  <= 1'b0;
      pol_q  <= 1'b0;
      cnt_q  <= '0;
      prev_q <= '0;
      meas_o <= '0;
      pol_o  <= 1'b0;
      evt_o  <= 1'b0;
      tout_o <= 1'b0;
    end else begin
      vs_q   <= vsync_i;
      vs_qq  <= vs_q;
      evt_o  <= 1'b0;
      tout_o <= 1'b0;
      if (frm_edge) begin
        evt_o  <= 1'b1;
        meas_o <= cnt_q;
        pol_o  <= pol_q;
        prev_q <= cnt_q;
        cnt_q  <= tick_i ? CNT_W'(1) : '0;
      end else if (hit_to) begin
        tout_o <= 1'b1;
        meas_o <= HI_V;
        prev_q <= HI_V;
        cnt_q  <= '0;
      end else begin
        if (tick_i) cnt_q <= cnt_inc;
        if (hit_qtr) pol_q <= vs_q;
      end
    end
  end
endmodule

// File: rtl/vmd_mode_filter.sv
module vmd_mode_filter
  import vmd_pkg::*;
#(
  parameter int CNT_W   = VMD_CNT_W,
  parameter int LO_TH   = VMD_LO_TH,
  parameter int PERSIST = VMD_PERSIST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             tout_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             pol_i,
  output logic [CNT_W-1:0] period_o,
  output logic             pol_o,
  output logic             present_o,
  output logic             irq_o
);
  localparam int RW = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO_TH);
  localparam int MW = CNT_W + 2;

  logic [MW-1:0] cur, cand, tcand, last_q;
  logic [RW-1:0] run_q;
  logic          cand_pres;

  always_comb begin
    cand_pres = (meas_i < LO_V) ? 1'b1 : present_o;
    cur       = {period_o, pol_o, present_o};
    cand      = {meas_i, pol_i, cand_pres};
    tcand     = {meas_i, pol_o, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o  <= '0;
      pol_o     <= 1'b0;
      present_o <= 1'b0;
      irq_o     <= 1'b0;
      last_q    <= '0;
      run_q     <= '0;
    end else begin
      irq_o <= 1'b0;
      if (tout_i) begin
        run_q <= '0;
        if (tcand != cur) begin
          {period_o, pol_o, present_o} <= tcand;
          irq_o <= 1'b1;
        end
      end else if (evt_i) begin
        if (cand == cur) begin
          run_q <= '0;
        end else if (run_q != '0 && cand == last_q) begin
          if (run_q == RW'(PERSIST - 1)) begin
            {period_o, pol_o, present_o} <= cand;
            irq_o <= 1'b1;
            run_q <= '0;
          end else begin
            run_q <= run_q + RW'(1);
          end
        end else begin
          last_q <= cand;
          run_q  <= RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vsync_mode_det.sv
module vsync_mode_det
  import vmd_pkg::*;
#(
  parameter int DIV     = VMD_DIV,
  parameter int CNT_W   = VMD_CNT_W,
  parameter int HI_TH   = VMD_HI_TH,
  parameter int LO_TH   = VMD_LO_TH,
  parameter int PERSIST = VMD_PERSIST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             base_en_i,
  output logic [CNT_W-1:0] period_o,
  output logic             pol_o,
  output logic             present_o,
  output logic             irq_o
);
  logic             tick_w, evt_w, tout_w, fpol_w;
  logic [CNT_W-1:0] meas_w;

  vmd_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (base_en_i),
    .tick_o(tick_w)
  );

  vmd_frame_meter #(.CNT_W(CNT_W), .HI_TH(HI_TH)) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vsync_i(vsync_i),
    .tick_i (tick_w),
    .evt_o  (evt_w),
    .tout_o (tout_w),
    .meas_o (meas_w),
    .pol_o  (fpol_w)
  );

  vmd_mode_filter #(.CNT_W(CNT_W), .LO_TH(LO_TH), .PERSIST(PERSIST)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_w),
    .tout_i   (tout_w),
    .meas_i   (meas_w),
    .pol_i    (fpol_w),
    .period_o (period_o),
    .pol_o    (pol_o),
    .present_o(present_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/vmd_checker.sv
module vmd_checker #(
  parameter int DIV   = 76,
  parameter int CNT_W = 12,
  parameter int HI_TH = 4080,
  parameter int LO_TH = 4032
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             base_en_i,
  input logic             tick_i,
  input logic             evt_i,
  input logic             tout_i,
  input logic [CNT_W-1:0] meas_i,
  input logic [CNT_W-1:0] period_i,
  input logic             pol_i,
  input logic             present_i,
  input logic             irq_i
);
  localparam int EW = $clog2(DIV + 1);
  logic [EW-1:0] en_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_cnt_q <= '0;
    else if (tick_i)    en_cnt_q <= '0;
    else if (base_en_i) en_cnt_q <= en_cnt_q + EW'(1);
  end

  // R1
  tick_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (base_en_i && en_cnt_q == EW'(DIV - 1)));
  // R5
  meas_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |-> (meas_i < CNT_W'(HI_TH)));
  // R3
  pres_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_i) |-> (period_i < CNT_W'(LO_TH)));
  // R5
  pres_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(present_i) |-> (period_i == CNT_W'(HI_TH)));
  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> $stable({period_i, pol_i, present_i}));
  // R7
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(evt_i || tout_i));
endmodule

bind vsync_mode_det vmd_checker #(
  .DIV(DIV), .CNT_W(CNT_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .base_en_i(base_en_i),
  .tick_i   (tick_w),
  .evt_i    (evt_w),
  .tout_i   (tout_w),
  .meas_i   (meas_w),
  .period_i (period_o),
  .pol_i    (pol_o),
  .present_i(present_o),
  .irq_i    (irq_o)
);

// File: tb/sim_vsync_mode_det.sv
module sim_vsync_mode_det;
  localparam int DIV = 4;
  localparam int CW  = 12;
  localparam int HI  = 240;
  localparam int LO  = 192;
  localparam int PW  = 20;
  localparam int NV  = 14;
  // frames, ticks/frame (0 = idle cycles), active_low, half_rate, period, pol, pres, irqs
  localparam int TBL [NV][8] = '{
    '{9, 100, 0, 0, 100, 0, 1, 1},
    '{9, 150, 0, 0, 150, 0, 1, 1},
    '{9, 150, 1, 0, 150, 1, 1, 1},
    '{9, 210, 1, 0, 210, 1, 1, 1},
    '{3000, 0, 1, 0, 240, 1, 0, 1},
    '{9, 210, 1, 0, 210, 1, 0, 1},
    '{9, 180, 1, 0, 180, 1, 1, 1},
    '{9, 180, 1, 0, 180, 1, 1, 0},
    '{3, 120, 1, 0, 180, 1, 1, 0},
    '{9, 180, 1, 0, 180, 1, 1, 0},
    '{4, 120, 1, 0, 180, 1, 1, 0},
    '{9, 180, 1, 0, 180, 1, 1, 2},
    '{9, 180, 1, 1, 90, 1, 1, 1},
    '{9, 180, 1, 0, 180, 1, 1, 1}
  };
  localparam string TAG [NV] = '{"R2 R6", "R2", "R6", "R4", "R5", "R4",
    "R3", "R9", "R7", "R7 R9", "R7", "R7", "R1", "R1 R2"};

  logic          clk_i = 1'b0, rst_ni = 1'b0, vsync_i = 1'b0, base_en_i = 1'b1;
  logic [CW-1:0] period_o;
  logic          pol_o, present_o, irq_o;
  int            n_chk = 0, n_fail = 0, irq_cnt = 0, mon_bad = 0;
  logic          irq_prev = 1'b0;
  logic [CW+1:0] last_out = '0;
  bit            done = 0;

  always #10 clk_i = ~clk_i;

  vsync_mode_det #(.DIV(DIV), .CNT_W(CW), .HI_TH(HI), .LO_TH(LO)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_i(vsync_i), .base_en_i(base_en_i),
    .period_o(period_o), .pol_o(pol_o), .present_o(present_o), .irq_o(irq_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      irq_prev = 1'b0;
      last_out = '0;
    end else begin
      if (irq_o) irq_cnt++;
      if (irq_o && irq_prev) mon_bad++;
      if (!irq_o && {period_o, pol_o, present_o} != last_out) mon_bad++;
      last_out = {period_o, pol_o, present_o};
      irq_prev = irq_o;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int frames, input int n, input bit lo, input bit half);
    if (n == 0) begin
      for (int c = 0; c < frames; c++) begin
        @(negedge clk_i);
        vsync_i   = lo;
        base_en_i = 1'b1;
      end
    end else begin
      for (int f = 0; f < frames; f++) begin
        for (int c = 0; c < n * DIV; c++) begin
          @(negedge clk_i);
          vsync_i   = (c < PW) ? ~lo : lo;
          base_en_i = half ? ~base_en_i : 1'b1;
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10
    check("R10", "period", int'(period_o), 0);
    check("R10", "pol", int'(pol_o), 0);
    check("R10", "present", int'(present_o), 0);
    check("R10", "irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      irq_cnt = 0;
      run_vec(TBL[v][0], TBL[v][1], TBL[v][2] != 0, TBL[v][3] != 0);
      check(TAG[v], "period", int'(period_o), TBL[v][4]);
      check(TAG[v], "pol", int'(pol_o), TBL[v][5]);
      check(TAG[v], "present", int'(present_o), TBL[v][6]);
      check(TAG[v], "irq count", irq_cnt, TBL[v][7]);
    end
    // R10 reset mid-run clears everything
    @(negedge clk_i);
    rst_ni  = 1'b0;
    vsync_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R10", "period in reset", int'(period_o), 0);
    check("R10", "present in reset", int'(present_o), 0);
    rst_ni  = 1'b1;
    irq_cnt = 0;
    // R5 dead line from reset: one timeout irq, later timeouts silent
    run_vec(1500, 0, 1'b0, 1'b0);
    check("R5", "period after timeout", int'(period_o), HI);
    check("R5", "present after timeout", int'(present_o), 0);
    check("R5", "pol after timeout", int'(pol_o), 0);
    check("R5", "irq count", irq_cnt, 1);
    // R8 monitor of pulse width and output hold
    check("R8", "monitor violations", mon_bad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule